// File: doc/BRIEF.md
# Locked Bus Cycle Sequencer

This block sits in a processor bus interface and controls the bus lock indicator for multi-cycle atomic sequences, such as a read-modify-write pair or the two cycles of an interrupt acknowledge. The bus unit offers one cycle request at a time. Each request carries a locked flag, a last-of-sequence flag and a tag. The sequencer accepts the request and starts the cycle with a one-clock address strobe. It then waits for the transfer-ready input, which ends the cycle.

The lock output is active low and comes from a register. It falls together with the strobe of the first locked cycle. It rises only in the clock after the ready that ends the final locked cycle. Once it has risen, it stays high for at least one clock before another locked sequence can begin.

While the lock is held, the block refuses a bus hold request. It still obeys the address-hold input, which stalls new cycles, and the back-off input, which aborts the current cycle so that it runs again later. A hold request that arrives during a locked sequence is granted as soon as the lock drops, before the next sequence starts. Only one bus cycle is outstanding at any time.

Top module: `lock_sequencer`

## Requirements
- R1: During reset, busLockN is 1, addrStrobe is 0, holdAck is 0 and busTag is 0.
- R2: busLockN (active low) goes to 0 in the same clock in which addrStrobe is high for the first cycle of a locked sequence. Cycles requested with reqLocked = 0 leave busLockN at 1.
- R3: busLockN stays at 0 without a break across every cycle of the sequence. It returns to 1 in the clock after the xferRdy that completes the cycle flagged reqLast. With no stalls, a sequence of N cycles that each have W wait clocks holds busLockN low for N*(W+2)-1 clocks.
- R4: Between two back-to-back locked sequences, busLockN is high for exactly one clock.
- R5: holdAck is never 1 while busLockN is 0. No addrStrobe follows a clock in which holdAck is 1.
- R6: A holdReq that is pending during a locked sequence produces holdAck in the clock after busLockN rises. The next sequence starts only after the hold has ended.
- R7: While the bus is idle and unlocked, holdAck rises one clock after holdReq rises. It falls one clock after holdReq falls, and it has priority over a pending request.
- R8: An addrHold that is high in a clock blocks addrStrobe in the next clock. addrHold does not release the lock.
- R9: backOff aborts the outstanding cycle and overrides xferRdy in the same clock. busLockN stays low. The aborted cycle is reissued with the same busTag in the clock after the clock in which backOff is first low again.
- R10: addrStrobe is a one-clock pulse. It is high in the clock after the one in which reqTake is 1. No new request is accepted until the outstanding cycle has received its xferRdy.
- R11: busTag takes the value of reqTag on acceptance. It changes only together with addrStrobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | A cycle request is offered |
| reqLocked | input | 1 | The offered cycle belongs to a locked sequence |
| reqLast | input | 1 | The offered cycle is the last one of its sequence |
| reqTag | input | TAG_W | Identifier that travels with the request |
| reqTake | output | 1 | The request is accepted at this clock edge |
| xferRdy | input | 1 | Transfer ready; ends the outstanding cycle |
| holdReq | input | 1 | Request from another master to take the bus |
| addrHold | input | 1 | Address hold; stalls the start of new cycles |
| backOff | input | 1 | Abort the current cycle and retry it later |
| addrStrobe | output | 1 | One-clock pulse that starts a bus cycle |
| busTag | output | TAG_W | Tag of the cycle on the bus |
| busLockN | output | 1 | Bus lock indicator, active low |
| holdAck | output | 1 | Bus hold granted |

## Verification
The bound checker tests, on every clock, the rules that hold in all situations. The lock falls only together with a strobe and rises only after an unaborted ready. Hold is never granted while the lock is held, and no strobe follows a hold or an address-hold clock. The strobe is a single pulse, the tag moves only with a strobe, and back-off never releases the lock. The exact timing can only be shown by the bench's scenarios: the lock duration as a function of sequence length and wait states, the single-clock gap, the clock in which a deferred hold is granted, and the reissue clock and tag after a back-off. The bench sweeps these over small ranges of lengths, wait states and window positions.

// File: rtl/lock_seq_pkg.sv
`timescale 1ns/1ps
package lock_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BUSY  = 2'd1,
    ST_RETRY = 2'd2,
    ST_HOLD  = 2'd3
  } seqState_t;

  // Strobes from control to datapath, one clock each
  typedef struct packed {
    logic loadReq;
    logic fireStrobe;
    logic setLock;
    logic clrLock;
    logic setHold;
    logic clrHold;
  } seqCtl_t;

endpackage

// File: rtl/lock_seq_ctrl.sv
`timescale 1ns/1ps
module lock_seq_ctrl
  import lock_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqLocked,
  input  logic    xferRdy,
  input  logic    holdReq,
  input  logic    addrHold,
  input  logic    backOff,
  input  logic    lockActive,
  input  logic    curLocked,
  input  logic    curLast,
  output seqCtl_t ctl,
  output logic    reqTake
);

  seqState_t stateQ;
  seqState_t stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD  = stateQ;
    ctl     = '0;
    reqTake = 1'b0;
    case (stateQ)
      ST_IDLE: begin
        // a hold waiting on an unlocked idle bus wins over new work
        if (holdReq && !lockActive) begin
          ctl.setHold = 1'b1;
          stateD      = ST_HOLD;
        end else if (reqValid && !addrHold && !backOff) begin
          ctl.loadReq    = 1'b1;
          ctl.fireStrobe = 1'b1;
          ctl.setLock    = reqLocked;
          reqTake        = 1'b1;
          stateD         = ST_BUSY;
        end
      end
      ST_BUSY: begin
        if (backOff) begin
          stateD = ST_RETRY;
        end else if (xferRdy) begin
          ctl.clrLock = curLocked && curLast;
          stateD      = ST_IDLE;
        end
      end
      ST_RETRY: begin
        if (!backOff && !addrHold) begin
          ctl.fireStrobe = 1'b1;
          stateD         = ST_BUSY;
        end
      end
      ST_HOLD: begin
        if (!holdReq) begin
          ctl.clrHold = 1'b1;
          stateD      = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/lock_seq_dp.sv
`timescale 1ns/1ps
module lock_seq_dp
  import lock_seq_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqCtl_t          ctl,
  input  logic [TAG_W-1:0] reqTag,
  input  logic             reqLocked,
  input  logic             reqLast,
  output logic             busLockN,
  output logic             holdAck,
  output logic             addrStrobe,
  output logic [TAG_W-1:0] busTag,
  output logic             curLocked,
  output logic             curLast
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busLockN   <= 1'b1;
      holdAck    <= 1'b0;
      addrStrobe <= 1'b0;
      busTag     <= '0;
      curLocked  <= 1'b0;
      curLast    <= 1'b0;
    end else begin
      addrStrobe <= ctl.fireStrobe;
      if (ctl.loadReq) begin
        busTag    <= reqTag;
        curLocked <= reqLocked;
        curLast   <= reqLast;
      end
      if (ctl.setLock)      busLockN <= 1'b0;
      else if (ctl.clrLock) busLockN <= 1'b1;
      if (ctl.setHold)      holdAck <= 1'b1;
      else if (ctl.clrHold) holdAck <= 1'b0;
    end
  end

endmodule

// File: rtl/lock_sequencer.sv
`timescale 1ns/1ps
module lock_sequencer
  import lock_seq_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqLocked,
  input  logic             reqLast,
  input  logic [TAG_W-1:0] reqTag,
  output logic             reqTake,
  input  logic             xferRdy,
  input  logic             holdReq,
  input  logic             addrHold,
  input  logic             backOff,
  output logic             addrStrobe,
  output logic [TAG_W-1:0] busTag,
  output logic             busLockN,
  output logic             holdAck
);

  seqCtl_t ctl;
  logic    curLocked;
  logic    curLast;

  lock_seq_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqLocked  (reqLocked),
    .xferRdy    (xferRdy),
    .holdReq    (holdReq),
    .addrHold   (addrHold),
    .backOff    (backOff),
    .lockActive (!busLockN),
    .curLocked  (curLocked),
    .curLast    (curLast),
    .ctl        (ctl),
    .reqTake    (reqTake)
  );

  lock_seq_dp #(.TAG_W(TAG_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .reqTag     (reqTag),
    .reqLocked  (reqLocked),
    .reqLast    (reqLast),
    .busLockN   (busLockN),
    .holdAck    (holdAck),
    .addrStrobe (addrStrobe),
    .busTag     (busTag),
    .curLocked  (curLocked),
    .curLast    (curLast)
  );

endmodule

// File: rtl/lock_sequencer_chk.sv
`timescale 1ns/1ps
module lock_sequencer_chk #(
  parameter int TAG_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             busLockN,
  input logic             addrStrobe,
  input logic             holdAck,
  input logic             xferRdy,
  input logic             addrHold,
  input logic             backOff,
  input logic [TAG_W-1:0] busTag
);

  p_lock_with_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busLockN) |-> addrStrobe);

  p_release_on_ready_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busLockN) |-> ($past(xferRdy) && !$past(backOff)));

  p_gap_unlocked_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busLockN) |-> !addrStrobe);

  p_no_hold_locked_r5: assert property (@(posedge clk) disable iff (!rstN)
    !busLockN |-> !holdAck);

  p_no_strobe_after_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    holdAck |=> !addrStrobe);

  p_addr_hold_stalls_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(addrHold) |-> !addrStrobe);

  p_backoff_keeps_lock_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(backOff) && !$past(busLockN)) |-> !busLockN);

  p_backoff_no_strobe_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(backOff) |-> !addrStrobe);

  p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    addrStrobe |=> !addrStrobe);

  p_tag_with_strobe_r11: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(busTag) |-> addrStrobe);

endmodule

bind lock_sequencer lock_sequencer_chk #(.TAG_W(TAG_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .busLockN   (busLockN),
  .addrStrobe (addrStrobe),
  .holdAck    (holdAck),
  .xferRdy    (xferRdy),
  .addrHold   (addrHold),
  .backOff    (backOff),
  .busTag     (busTag)
);

// File: tb/lock_sequencer_tb_top.sv
`timescale 1ns/1ps
module lock_sequencer_tb_top;
  localparam int TAG_W = 8;
  localparam int LOG_N = 64;
  localparam int RUN_N = 48;
  localparam int TAG0  = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqLocked = 1'b0, reqLast = 1'b0;
  logic [TAG_W-1:0] reqTag = '0;
  logic reqTake;
  logic xferRdy = 1'b0, holdReq = 1'b0, addrHold = 1'b0, backOff = 1'b0;
  logic addrStrobe, busLockN, holdAck;
  logic [TAG_W-1:0] busTag;

  always #2.5 clk = ~clk;

  lock_sequencer #(.TAG_W(TAG_W)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLocked(reqLocked),
    .reqLast(reqLast), .reqTag(reqTag), .reqTake(reqTake), .xferRdy(xferRdy),
    .holdReq(holdReq), .addrHold(addrHold), .backOff(backOff),
    .addrStrobe(addrStrobe), .busTag(busTag), .busLockN(busLockN), .holdAck(holdAck)
  );

  int checks = 0;
  int failures = 0;
  int wdog = 0;
  bit done = 0;

  // per-clock logs of one scenario
  bit lockLog[LOG_N], stbLog[LOG_N], hackLog[LOG_N], rdyLog[LOG_N];
  int tagLog[LOG_N];
  int cyc;

  // scenario configuration
  int waitW, seqCnt, seqIdx, seqLeft, tagNext;
  int seqLens[4];
  bit seqLockedCfg, rdyInBoff;
  int aFrom, aTo, hFrom, hTo, bFrom, bTo;
  bit takePrev, outst;
  int wcnt;

  // analysis results
  int nStb, nLow, nRuns, firstLow, riseIdx, gapHigh, lastRdyB4Rise;
  int holdFirst, holdLast, holdWhileLocked, stbAfterHold, firstStbAfterRise;
  int stbIdx[8];

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; reqValid = 0; reqLocked = 0; reqLast = 0; reqTag = '0;
    xferRdy = 0; holdReq = 0; addrHold = 0; backOff = 0;
    repeat (2) @(negedge clk);
    chk("R1", "lock during reset", int'(busLockN), 1);
    chk("R1", "strobe during reset", int'(addrStrobe), 0);
    chk("R1", "holdAck during reset", int'(holdAck), 0);
    chk("R1", "tag during reset", int'(busTag), 0);
    rstN = 1'b1;
    takePrev = 0; outst = 0; wcnt = 0; cyc = 0;
  endtask

  task automatic setup(input int w, input bit locked, input int n0, input int n1);
    waitW = w; seqLockedCfg = locked;
    seqLens[0] = n0; seqLens[1] = n1; seqLens[2] = 0; seqLens[3] = 0;
    seqCnt = (n1 > 0) ? 2 : 1;
    seqLeft = n0; seqIdx = 1; tagNext = TAG0;
    aFrom = 0; aTo = 0; hFrom = 0; hTo = 0; bFrom = 0; bTo = 0; rdyInBoff = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    lockLog[cyc] = busLockN; stbLog[cyc] = addrStrobe;
    hackLog[cyc] = holdAck; tagLog[cyc] = int'(busTag);
    if (takePrev) begin
      seqLeft--; tagNext++;
      if (seqLeft == 0 && seqIdx < seqCnt) begin
        seqLeft = seqLens[seqIdx]; seqIdx++;
      end
    end
    reqValid  = (seqLeft > 0);
    reqLast   = (seqLeft == 1);
    reqLocked = seqLockedCfg;
    reqTag    = TAG_W'(tagNext);
    addrHold  = (cyc >= aFrom && cyc < aTo);
    holdReq   = (cyc >= hFrom && cyc < hTo);
    backOff   = (cyc >= bFrom && cyc < bTo);
    xferRdy   = 1'b0;
    rdyLog[cyc] = 0;
    if (addrStrobe) begin outst = 1; wcnt = 0; end
    if (backOff) begin
      outst = 0;
      if (rdyInBoff) xferRdy = 1'b1;
    end else if (outst) begin
      if (wcnt == waitW) begin xferRdy = 1'b1; rdyLog[cyc] = 1; outst = 0; end
      else wcnt++;
    end
    #1;
    takePrev = reqTake;
    cyc++;
  endtask

  task automatic analyze();
    nStb = 0; nLow = 0; nRuns = 0; firstLow = -1; riseIdx = -1; gapHigh = 0;
    holdFirst = -1; holdLast = -1; holdWhileLocked = 0; stbAfterHold = 0;
    firstStbAfterRise = -1; lastRdyB4Rise = -1;
    for (int k = 0; k < 8; k++) stbIdx[k] = -1;
    for (int k = 0; k < RUN_N; k++) begin
      if (stbLog[k]) begin
        if (nStb < 8) stbIdx[nStb] = k;
        nStb++;
      end
      if (!lockLog[k]) begin
        nLow++;
        if (firstLow < 0) firstLow = k;
        if (k == 0 || lockLog[k-1]) nRuns++;
      end else if (nRuns == 1 && k > 0 && !lockLog[k-1] && riseIdx < 0) begin
        riseIdx = k;
      end
      if (nRuns == 1 && lockLog[k] && riseIdx >= 0) gapHigh++;
      if (hackLog[k]) begin
        if (holdFirst < 0) holdFirst = k;
        holdLast = k;
        if (!lockLog[k]) holdWhileLocked++;
      end
      if (k > 0 && stbLog[k] && hackLog[k-1]) stbAfterHold++;
    end
    if (riseIdx >= 0) begin
      for (int k = 0; k < riseIdx; k++) if (rdyLog[k]) lastRdyB4Rise = k;
      for (int k = RUN_N - 1; k >= riseIdx; k--) if (stbLog[k]) firstStbAfterRise = k;
    end
  endtask

  task automatic runScen();
    for (int k = 0; k < RUN_N; k++) tick();
    analyze();
  endtask

  always @(posedge clk) begin
    wdog++;
    if (wdog > 150000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=150000", wdog);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // single locked sequences: lengths x wait states
    for (int n = 1; n <= 4; n++) begin
      for (int w = 0; w <= 2; w++) begin
        doReset(); setup(w, 1, n, 0); runScen();
        chk("R10", "strobe count", nStb, n);
        chk("R2", "lock falls at first strobe", firstLow, stbIdx[0]);
        chk("R2", "first strobe clock", stbIdx[0], 1);
        chk("R3", "lock low clocks", nLow, n * (w + 2) - 1);
        chk("R3", "lock runs", nRuns, 1);
        chk("R3", "rise after last ready", riseIdx, lastRdyB4Rise + 1);
        chk("R5", "hold while locked", holdWhileLocked, 0);
        for (int k = 0; k < n; k++)
          chk("R11", "tag of cycle", tagLog[stbIdx[k]], TAG0 + k);
      end
    end

    // unlocked cycles never touch the lock
    for (int n = 1; n <= 3; n++) begin
      for (int w = 0; w <= 1; w++) begin
        doReset(); setup(w, 0, n, 0); runScen();
        chk("R2", "unlocked lock low clocks", nLow, 0);
        chk("R10", "unlocked strobe count", nStb, n);
        chk("R10", "strobe spacing", stbIdx[1] < 0 ? w + 2 : stbIdx[1] - stbIdx[0], w + 2);
      end
    end

    // back-to-back locked pairs
    for (int w = 0; w <= 2; w++) begin
      doReset(); setup(w, 1, 2, 2); runScen();
      chk("R4", "two lock runs", nRuns, 2);
      chk("R4", "gap high clocks", gapHigh, 1);
      chk("R10", "b2b strobe count", nStb, 4);
    end

    // hold pending during a locked sequence
    for (int w = 0; w <= 2; w++) begin
      doReset(); setup(w, 1, 2, 2); hFrom = 2; hTo = 2 * w + 9; runScen();
      chk("R5", "hold while locked", holdWhileLocked, 0);
      chk("R5", "strobe after hold clock", stbAfterHold, 0);
      chk("R6", "rise clock", riseIdx, 2 * w + 4);
      chk("R6", "hold grant clock", holdFirst, riseIdx + 1);
      chk("R7", "hold release clock", holdLast, hTo);
      chk("R6", "next sequence strobe", firstStbAfterRise, hTo + 2);
    end

    // hold on an idle unlocked bus
    for (int s = 2; s <= 4; s++) begin
      for (int len = 1; len <= 3; len++) begin
        doReset(); setup(0, 0, 0, 0); hFrom = s; hTo = s + len; runScen();
        chk("R7", "idle hold rise", holdFirst, s + 1);
        chk("R7", "idle hold fall", holdLast, s + len);
        chk("R7", "idle no strobe", nStb, 0);
      end
    end
    doReset(); setup(0, 0, 1, 0); hFrom = 0; hTo = 4; runScen();
    chk("R7", "hold beats request", stbIdx[0], 6);
    chk("R5", "strobe after hold clock", stbAfterHold, 0);

    // address hold inside a locked pair
    for (int t = 3; t <= 6; t++) begin
      doReset(); setup(0, 1, 2, 0); aFrom = 2; aTo = t; runScen();
      chk("R8", "second strobe clock", stbIdx[1], t + 1);
      chk("R8", "lock unbroken", nRuns, 1);
      chk("R8", "lock low clocks", nLow, t + 1);
    end

    // back-off of a locked cycle
    for (int t = 3; t <= 5; t++) begin
      for (int r = 0; r <= 1; r++) begin
        doReset(); setup(2, 1, 2, 0); bFrom = 2; bTo = t; rdyInBoff = bit'(r); runScen();
        chk("R9", "strobe count with retry", nStb, 3);
        chk("R9", "lock unbroken", nRuns, 1);
        chk("R9", "retry strobe clock", stbIdx[1], t + 1);
        chk("R9", "retry keeps tag", tagLog[stbIdx[1]], TAG0);
        chk("R11", "tag after retry", tagLog[stbIdx[2]], TAG0 + 1);
        chk("R9", "lock low clocks", nLow, t + 7);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule